// File: doc/BRIEF.md
# Cache-Line Zeroing Engine

This unit carries out a request to clear one data-cache line to zero. On a request it rounds the supplied byte address down to the start of the line that holds it. It then writes a 32-bit zero word at each word of that line over a simple memory write port, moving to the next word only when the port acknowledges the current one. The line size comes from a 3-bit size code. A compatibility mode can instead read a two-bit field in a hardware configuration word. When that mode is on and the field holds 1, the line is forced to 32 bytes.

When the last word has been written, the unit compares the held load-reserve address with the line base. If they are equal, it raises a one-cycle invalidate so that the reservation register is set to all ones, which marks it as invalid. In that same cycle `done` pulses. Requests that arrive while a line is being cleared are dropped.

Top module: `line_zero_engine`

## Requirements
- R1: The line base is the request address with its low log2(line size) bits cleared, and every write address lies in the line that starts at that base.
- R2: Writes go to base+0, base+4, … up to base+line−4, in ascending order, one write per line word, with write data all zero.
- R3: While `wr_valid` is high and `wr_ack` is low, the write address holds and no word is counted. The next word is presented only after an acknowledge.
- R4: Size code c selects a line of 16<<c bytes for c = 0..3 (16, 32, 64, 128). Codes 4 to 7 select 128 bytes.
- R5: When `alt_mode` is high and `hwcfg[8:7]` equals 1, the line is 32 bytes whatever the size code. In every other case (mode off, or any other field value) the size code decides.
- R6: `done` is high for exactly one cycle, namely the cycle after the acknowledge of the last word.
- R7: `resv_inv` is high in the `done` cycle exactly when `resv_addr` equals the aligned line base. A reservation at an unaligned address inside the line does not match.
- R8: A request made while `busy` is high is ignored. The running line is unchanged and no extra line follows.
- R9: After reset, `busy`, `wr_valid`, `done` and `resv_inv` are low.
- R10: `resv_inv` is never high outside a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Zero-line request strobe, taken when idle |
| req_addr | input | 32 | Byte address inside the target line |
| size_code | input | 3 | Line size code, 16<<code bytes, saturating at 128 |
| alt_mode | input | 1 | Enables the configuration-word override |
| hwcfg | input | 32 | Hardware configuration word; bits 8:7 = 1 force 32 bytes in alt mode |
| resv_addr | input | 32 | Currently held reservation address |
| wr_ack | input | 1 | Memory accepted the presented word |
| busy | output | 1 | A line is being cleared |
| wr_valid | output | 1 | A word write is presented |
| wr_addr | output | 32 | Byte address of the presented word |
| wr_data | output | 32 | Write data, always zero |
| done | output | 1 | One-cycle completion pulse |
| resv_inv | output | 1 | Set reservation to all ones (invalid) |

## Verification
The hardest case to reach is a second request that lands while a line is still being cleared, mid-way through a sequence whose acknowledges are being held back. The bench covers it by stalling the acknowledge on alternate cycles and raising a request with a different address and size part-way through the writes. It then checks that the word addresses keep following the first line and that no further writes appear after `done`. The size override is covered by vectors that vary the mode bit, the configuration field and the size code one at a time. Reservation addresses are chosen to sit on the base, one line beyond it, and at an unaligned address inside the line.

// File: rtl/lz_pkg.sv
package lz_pkg;
    typedef enum logic [1:0] {
        LZ_IDLE  = 2'd0,
        LZ_WRITE = 2'd1,
        LZ_FIN   = 2'd2
    } lz_state_e;
endpackage

// File: rtl/lz_size_sel.sv
module lz_size_sel #(
    parameter int CODE_W     = 3,
    parameter int CFG_W      = 32,
    parameter int MIN_LOG2   = 4,
    parameter int MAX_LOG2   = 7,
    parameter int FORCE_LOG2 = 5,
    parameter int FIELD_LSB  = 7,
    localparam int LOG_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic [CODE_W-1:0] size_code,
    input  logic              alt_mode,
    input  logic [CFG_W-1:0]  hwcfg,
    output logic [LOG_W-1:0]  line_log2
);
    logic [1:0] field;
    int unsigned raw;

    assign field = hwcfg[FIELD_LSB +: 2];

    always_comb begin
        raw = MIN_LOG2 + int'(size_code);
        if (raw > MAX_LOG2) begin
            raw = MAX_LOG2;
        end
        if (alt_mode && field == 2'd1) begin
            line_log2 = LOG_W'(FORCE_LOG2);
        end else begin
            line_log2 = LOG_W'(raw);
        end
    end
endmodule

// File: rtl/lz_align.sv
module lz_align #(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 7,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LOG_W-1:0]  line_log2,
    output logic [ADDR_W-1:0] base
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < MAX_LOG2) begin : g_low
            assign base[i] = addr[i] & (int'(line_log2) <= i);
        end else begin : g_high
            assign base[i] = addr[i];
        end
    end
endmodule

// File: rtl/lz_seq.sv
module lz_seq
    import lz_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 7,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int IDX_W   = MAX_LOG2 - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [LOG_W-1:0]  line_log2,
    input  logic              wr_ack,
    input  logic [ADDR_W-1:0] resv_addr,
    output logic              busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              done,
    output logic              resv_inv
);
    typedef struct packed {
        lz_state_e         st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
    } seq_t;

    seq_t s_d, s_q;
    logic [IDX_W:0] words;

    always_comb begin
        words = (IDX_W + 1)'(1) << (line_log2 - LOG_W'(2));
        s_d   = s_q;
        case (s_q.st)
            LZ_IDLE: begin
                if (req_valid) begin
                    s_d.st   = LZ_WRITE;
                    s_d.base = req_base;
                    s_d.idx  = '0;
                    s_d.last = IDX_W'(words - (IDX_W + 1)'(1));
                end
            end
            LZ_WRITE: begin
                if (wr_ack) begin
                    if (s_q.idx == s_q.last) begin
                        s_d.st = LZ_FIN;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            LZ_FIN:  s_d.st = LZ_IDLE;
            default: s_d.st = LZ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: LZ_IDLE, base: '0, idx: '0, last: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != LZ_IDLE);
    assign wr_valid = (s_q.st == LZ_WRITE);
    assign wr_addr  = s_q.base + {{(ADDR_W - IDX_W - 2){1'b0}}, s_q.idx, 2'b00};
    assign done     = (s_q.st == LZ_FIN);
    assign resv_inv = done && (resv_addr == s_q.base);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr)));

    // R2
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ack) |=> (done || (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(4))));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && req_valid) |=> $stable(s_q.base));
endmodule

// File: rtl/line_zero_engine.sv
module line_zero_engine #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int CODE_W   = 3,
    parameter int CFG_W    = 32,
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 7,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CODE_W-1:0] size_code,
    input  logic              alt_mode,
    input  logic [CFG_W-1:0]  hwcfg,
    input  logic [ADDR_W-1:0] resv_addr,
    input  logic              wr_ack,
    output logic              busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              resv_inv
);
    logic [LOG_W-1:0]  line_log2;
    logic [ADDR_W-1:0] base;

    lz_size_sel #(
        .CODE_W    (CODE_W),
        .CFG_W     (CFG_W),
        .MIN_LOG2  (MIN_LOG2),
        .MAX_LOG2  (MAX_LOG2),
        .FORCE_LOG2(5),
        .FIELD_LSB (7)
    ) u_size (
        .size_code(size_code),
        .alt_mode (alt_mode),
        .hwcfg    (hwcfg),
        .line_log2(line_log2)
    );

    lz_align #(
        .ADDR_W  (ADDR_W),
        .MAX_LOG2(MAX_LOG2)
    ) u_align (
        .addr     (req_addr),
        .line_log2(line_log2),
        .base     (base)
    );

    lz_seq #(
        .ADDR_W  (ADDR_W),
        .MAX_LOG2(MAX_LOG2)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_base (base),
        .line_log2(line_log2),
        .wr_ack   (wr_ack),
        .resv_addr(resv_addr),
        .busy     (busy),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .done     (done),
        .resv_inv (resv_inv)
    );

    assign wr_data = '0;

    // R10
    inv_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_inv |-> done);

    // R1
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));
endmodule

// File: tb/line_zero_engine_test.sv
`timescale 1ns/1ps
module line_zero_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  size_code = '0;
    logic        alt_mode = 1'b0;
    logic [31:0] hwcfg = '0;
    logic [31:0] resv_addr = '0;
    logic        wr_ack = 1'b0;
    logic        busy, wr_valid, done, resv_inv;
    logic [31:0] wr_addr, wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    line_zero_engine uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .size_code(size_code), .alt_mode(alt_mode), .hwcfg(hwcfg),
        .resv_addr(resv_addr), .wr_ack(wr_ack), .busy(busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .resv_inv(resv_inv)
    );

    // fields: addr[39:8] code[7:5] alt[4] fld[3:2] resv_kind[1] stall[0]
    localparam int NV = 9;
    localparam logic [39:0] VEC [NV] = '{
        {32'h0000_1234, 3'd0, 1'b0, 2'd0, 1'b1, 1'b0},
        {32'h8000_00FF, 3'd1, 1'b0, 2'd0, 1'b0, 1'b1},
        {32'h1234_5678, 3'd2, 1'b0, 2'd0, 1'b1, 1'b1},
        {32'hFFFF_FFFF, 3'd3, 1'b0, 2'd0, 1'b1, 1'b0},
        {32'h0000_0ABC, 3'd6, 1'b0, 2'd0, 1'b0, 1'b0},
        {32'h0000_0ABC, 3'd3, 1'b1, 2'd1, 1'b1, 1'b1},
        {32'h0000_0ABC, 3'd0, 1'b1, 2'd1, 1'b0, 1'b0},
        {32'h0000_0ABC, 3'd3, 1'b1, 2'd2, 1'b1, 1'b0},
        {32'h0000_0ABC, 3'd2, 1'b0, 2'd1, 1'b1, 1'b0}
    };

    function automatic int exp_line(input int code, input bit alt, input int fld);
        if (alt && fld == 1) return 32;
        if (code > 3) return 128;
        return 16 << code;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // resv_kind: 0 = base+line, 1 = base, 2 = unaligned inside line
    task automatic run_line(input logic [31:0] addr, input int code, input bit alt,
                            input int fld, input int resv_kind, input bit stall,
                            input bit poke);
        int line, nwr;
        logic [31:0] base;
        bit got_done;
        line = exp_line(code, alt, fld);
        base = addr & ~(32'(line) - 32'd1);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; size_code = 3'(code); alt_mode = alt;
        hwcfg = (32'h5A5A_5A5A & ~(32'h3 << 7)) | (32'(fld) << 7);
        resv_addr = (resv_kind == 1) ? base :
                    (resv_kind == 2) ? base + 32'd4 : base + 32'(line);
        @(negedge clk);
        req_valid = 1'b0;
        nwr = 0; got_done = 1'b0;
        for (int cyc = 0; cyc < 400 && !got_done; cyc++) begin
            wr_ack = 1'b0;
            req_valid = 1'b0;
            if (poke && cyc == 1) begin
                req_valid = 1'b1; req_addr = 32'h7000_0000; size_code = 3'd0;
            end
            if (done) begin
                got_done = 1'b1;
                // R2 word count, R6 timing
                chk(nwr == line / 4, "R2", 32'(nwr), 32'(line / 4));
                // R7 reservation invalidate
                chk(resv_inv == (resv_kind == 1), "R7", 32'(resv_inv), 32'(resv_kind == 1));
            end else begin
                // R6: done must follow the last acknowledge at once
                chk(nwr < line / 4, "R6", 32'(nwr), 32'(line / 4));
                // R10
                chk(!resv_inv, "R10", 32'(resv_inv), 32'd0);
                if (wr_valid) begin
                    // R1 R3 R4 R5 R8: address follows the expected base and size
                    chk(wr_addr == base + 32'(4 * nwr), "R1", wr_addr, base + 32'(4 * nwr));
                    chk(wr_data == 32'd0, "R2", wr_data, 32'd0);
                    if (stall && (cyc % 2 == 0)) begin
                        wr_ack = 1'b0;
                    end else begin
                        wr_ack = 1'b1;
                        nwr++;
                    end
                end
            end
            @(negedge clk);
        end
        wr_ack = 1'b0;
        req_valid = 1'b0;
        chk(got_done, "R6", 32'(got_done), 32'd1);
        // R6 pulse width, R8 no extra line after a dropped request
        chk(!done && !wr_valid && !busy, "R6", {29'd0, done, wr_valid, busy}, 32'd0);
        @(negedge clk);
        chk(!wr_valid && !busy, "R8", {30'd0, wr_valid, busy}, 32'd0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy && !wr_valid && !done && !resv_inv, "R9",
            {28'd0, busy, wr_valid, done, resv_inv}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_valid, "R9", {30'd0, busy, wr_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_line(VEC[i][39:8], int'(VEC[i][7:5]), VEC[i][4], int'(VEC[i][3:2]),
                     int'(VEC[i][1]), VEC[i][0], 1'b0);
        end

        // R8: request during a stalled sequence is dropped
        run_line(32'h0000_4444, 2, 1'b0, 0, 1, 1'b1, 1'b1);
        // R7: reservation at an unaligned address inside the line does not match
        run_line(32'h0000_2010, 1, 1'b0, 0, 2, 1'b0, 0);
        // R4: largest code with back-to-back acknowledges
        run_line(32'h0001_00FC, 7, 1'b0, 0, 1, 1'b0, 0);
        // R5: override field 3 does not force
        run_line(32'h0000_0F00, 0, 1'b1, 3, 0, 1'b0, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule